// File: doc/BRIEF.md
# Retriggerable Digital One-Shot

This block is a synchronous monostable pulse generator. A qualified edge on either of two trigger inputs starts an output pulse that lasts a programmable number of system clock cycles. One input fires on its rising edge and the other on its falling edge, and each input is enabled only while the other sits at its idle level. The block drives complementary outputs. An active-low clear input ends a pulse early and keeps the block idle for as long as it is held low.

A static mode input selects between two behaviours. With retriggering enabled, a new trigger during a pulse restarts the timing, so the pulse ends one full period after the last accepted trigger. A retrigger that comes too soon after the previous (re)start is discarded; the limit is two fifths of the period. With retriggering disabled, the pulse is always exactly one period long and triggers that arrive while it runs are dropped. The trigger and clear inputs are asynchronous and each passes through a two-stage synchronizer. The period and the mode are expected to be quasi-static. The period is captured whenever a pulse starts or restarts.

Top module: `oneshot_pulse`

## Requirements
- R1: A rising edge on `trig_rise_i` while `trig_fall_i` is high starts a pulse. `q_o` goes high at the third clock edge after the input change and stays high for exactly P cycles, where P is the captured period.
- R2: A falling edge on `trig_fall_i` while `trig_rise_i` is low starts a pulse with the same timing as R1.
- R3: A rising edge on `trig_rise_i` is ignored while `trig_fall_i` is low. A falling edge on `trig_fall_i` is ignored while `trig_rise_i` is high. A falling edge on `trig_rise_i` and a rising edge on `trig_fall_i` never trigger.
- R4: With `retrig_en_i` = 1, an accepted trigger during a pulse restarts the timing, and `q_o` stays high until P cycles after that trigger. This includes a trigger that lands in the last cycle of the pulse, in which case `q_o` stays continuously high.
- R5: In retrigger mode, a retrigger is ignored if it arrives fewer than floor(2P/5) cycles after the previous start or restart, and the end of the pulse does not move. A retrigger spaced exactly floor(2P/5) cycles apart is accepted.
- R6: With `retrig_en_i` = 0, the pulse lasts exactly P cycles from the first trigger. Triggers during the pulse are ignored, including one in its last cycle, and they leave no pending pulse behind.
- R7: `q_o` is low from the second clock edge after `clear_n_i` falls. While the clear is low, no pulse starts, even when a trigger edge is qualified in the same cycle that the clear takes effect. After the clear is released, no pulse follows unless there is a new trigger.
- R8: `qn_o` is always the complement of `q_o`. During and after the system reset, `q_o` = 0 and `qn_o` = 1.
- R9: A `period_i` value of 0 gives a one-cycle pulse, the same as 1. Changing `period_i` during a pulse does not change the length of that pulse.
- R10: A channel whose `clear_n_i` is held low permanently stays at `q_o` = 0 and `qn_o` = 1 whatever its triggers do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| trig_rise_i | input | 1 | Trigger input that fires on its rising edge; idle low |
| trig_fall_i | input | 1 | Trigger input that fires on its falling edge; idle high |
| clear_n_i | input | 1 | Active-low clear that ends and blocks pulses |
| retrig_en_i | input | 1 | 1 = retriggerable, 0 = non-retriggerable |
| period_i | input | PER_W | Pulse length in clock cycles (0 counts as 1) |
| q_o | output | 1 | Pulse output, high while the pulse is active |
| qn_o | output | 1 | Complement of `q_o` |

## Verification
There are two same-cycle collisions. The first is a retrigger that arrives in the last cycle of a pulse. The bench places the second trigger exactly P cycles after the first. It then expects an unbroken high output in retrigger mode, and an on-time fall with no follow-on pulse in the other mode. The second collision is a trigger qualified in the same cycle that a synchronized clear takes effect. The bench drives both inputs on the same clock cycle and expects no pulse at all, either while the clear is held or after it is released.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

  // Action the pulse timer takes on the next clock edge.
  typedef enum logic [1:0] {
    TMR_HOLD = 2'd0,
    TMR_LOAD = 2'd1,
    TMR_STEP = 2'd2,
    TMR_STOP = 2'd3
  } tmr_act_e;

  // The minimum retrigger spacing is period * SPACE_NUM / SPACE_DEN.
  localparam int SPACE_NUM = 2;
  localparam int SPACE_DEN = 5;

endpackage

// File: rtl/oneshot_sync.sv
module oneshot_sync #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [1:0] stg_q;
    logic [1:0] stg_d;

    always_comb begin
      stg_d = {stg_q[0], d_i[b]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg_q <= {2{RST_VAL[b]}};
      end else begin
        stg_q <= stg_d;
      end
    end

    assign q_o[b] = stg_q[1];
  end

endmodule

// File: rtl/oneshot_edge.sv
module oneshot_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_lvl_i,
  input  logic fall_lvl_i,
  output logic trig_o
);

  logic rise_prev_q, fall_prev_q;
  logic rise_evt, fall_evt;

  // Each input is enabled only while the other one is at its idle level.
  always_comb begin
    rise_evt = rise_lvl_i & ~rise_prev_q & fall_lvl_i;
    fall_evt = ~fall_lvl_i & fall_prev_q & ~rise_lvl_i;
    trig_o   = rise_evt | fall_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_prev_q <= 1'b0;
      fall_prev_q <= 1'b1;
    end else begin
      rise_prev_q <= rise_lvl_i;
      fall_prev_q <= fall_lvl_i;
    end
  end

endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer
  import oneshot_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_ok_i,
  input  logic          trig_i,
  input  logic          retrig_en_i,
  input  logic [CW-1:0] period_i,
  output logic          active_o
);

  localparam int PW = CW + 3;

  logic          active_q, active_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] per_q, thr_q;
  logic [CW-1:0] per_eff, thr_new;
  logic [PW-1:0] prod;
  logic          load_en;
  tmr_act_e      act;

  always_comb begin
    per_eff = (period_i == '0) ? CW'(1) : period_i;
    prod    = PW'(per_eff) * PW'(SPACE_NUM);
    thr_new = CW'(prod / PW'(SPACE_DEN));
  end

  // Priority: clear, then start, then accepted retrigger, then end of period.
  always_comb begin
    if (!clr_ok_i) begin
      act = TMR_STOP;
    end else if (!active_q) begin
      act = trig_i ? TMR_LOAD : TMR_HOLD;
    end else if (trig_i && retrig_en_i && (cnt_q >= thr_q)) begin
      act = TMR_LOAD;
    end else if (cnt_q >= per_q) begin
      act = TMR_STOP;
    end else begin
      act = TMR_STEP;
    end
  end

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    load_en  = 1'b0;
    case (act)
      TMR_LOAD: begin
        active_d = 1'b1;
        cnt_d    = CW'(1);
        load_en  = 1'b1;
      end
      TMR_STEP: cnt_d = cnt_q + CW'(1);
      TMR_STOP: begin
        active_d = 1'b0;
        cnt_d    = '0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      per_q    <= CW'(1);
      thr_q    <= '0;
    end else begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
      if (load_en) begin
        per_q <= per_eff;
        thr_q <= thr_new;
      end
    end
  end

  assign active_o = active_q;

  // R1: a trigger into an idle, uncleared timer starts the count at one.
  assert_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ok_i && !active_q && trig_i) |=> (active_q && cnt_q == CW'(1)));

  // R7: a synchronized clear leaves the timer idle on the next edge.
  assert_clear_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_ok_i) |=> (!active_q));

  // R9: while active, the count stays within one to the captured nonzero period.
  assert_count_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (per_q != '0 && cnt_q != '0 && cnt_q <= per_q));

  // R5: a retrigger that comes too early only advances the count.
  assert_short_retrig_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ok_i && active_q && trig_i && cnt_q < thr_q && cnt_q < per_q)
    |=> (active_q && cnt_q == $past(cnt_q) + CW'(1)));

  // R6: in non-retriggerable mode, a running pulse keeps its period and counts on.
  assert_no_retrig_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ok_i && active_q && !retrig_en_i && cnt_q < per_q)
    |=> (active_q && per_q == $past(per_q) && cnt_q == $past(cnt_q) + CW'(1)));

endmodule

// File: rtl/oneshot_pulse.sv
module oneshot_pulse #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_rise_i,
  input  logic             trig_fall_i,
  input  logic             clear_n_i,
  input  logic             retrig_en_i,
  input  logic [PER_W-1:0] period_i,
  output logic             q_o,
  output logic             qn_o
);

  localparam int         NSYNC   = 3;
  // Reset levels of the synchronizers: clear held active, triggers at idle.
  localparam logic [2:0] SYNC_RV = 3'b010;

  logic [NSYNC-1:0] raw, synced;
  logic             rise_s, fall_s, clr_s;
  logic             trig_ok;
  logic             active;

  assign raw = {clear_n_i, trig_fall_i, trig_rise_i};

  oneshot_sync #(.W(NSYNC), .RST_VAL(SYNC_RV)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw),
    .q_o   (synced)
  );

  assign rise_s = synced[0];
  assign fall_s = synced[1];
  assign clr_s  = synced[2];

  oneshot_edge u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .rise_lvl_i (rise_s),
    .fall_lvl_i (fall_s),
    .trig_o     (trig_ok)
  );

  oneshot_timer #(.CW(PER_W)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_ok_i    (clr_s),
    .trig_i      (trig_ok),
    .retrig_en_i (retrig_en_i),
    .period_i    (period_i),
    .active_o    (active)
  );

  // The synchronized clear cuts the output one cycle before the timer clears.
  always_comb begin
    q_o  = active & clr_s;
    qn_o = ~q_o;
  end

endmodule

// File: tb/oneshot_pulse_tb.sv
module oneshot_pulse_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        a_rise, a_fall, a_clr, a_ret;
  logic [15:0] a_per;
  logic        a_q, a_qn;
  logic        b_q, b_qn;
  int          cyc = 0;
  int          checks = 0;
  int          fails = 0;
  int          c;

  typedef struct {
    int    cy;
    logic  q;
    string tag;
  } exp_t;

  exp_t sbq[$];
  exp_t cur;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  oneshot_pulse #(.PER_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .trig_rise_i(a_rise), .trig_fall_i(a_fall),
    .clear_n_i(a_clr), .retrig_en_i(a_ret), .period_i(a_per),
    .q_o(a_q), .qn_o(a_qn)
  );

  // Second channel: clear held low permanently, triggers shared (R10).
  oneshot_pulse #(.PER_W(16)) dut2_i (
    .clk(clk), .rst_n(rst_n), .trig_rise_i(a_rise), .trig_fall_i(a_fall),
    .clear_n_i(1'b0), .retrig_en_i(1'b1), .period_i(16'd10),
    .q_o(b_q), .qn_o(b_qn)
  );

  task automatic expect_win(int from, int to, logic v, string tag);
    for (int i = from; i <= to; i++) sbq.push_back('{i, v, tag});
  endtask

  // Monitor: pops expectations and compares them on the falling edge.
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].cy <= cyc) begin
      cur = sbq.pop_front();
      checks++;
      if (cur.cy != cyc) begin
        fails++;
        $display("FAIL %s stale item cyc=%0d expected cyc=%0d", cur.tag, cyc, cur.cy);
      end else if (a_q !== cur.q || a_qn !== ~cur.q) begin
        fails++;
        $display("FAIL %s cyc=%0d q=%b qn=%b expected q=%b qn=%b",
                 cur.tag, cyc, a_q, a_qn, cur.q, ~cur.q);
      end
      checks++;
      if (b_q !== 1'b0 || b_qn !== 1'b1) begin
        fails++;
        $display("FAIL R10 cyc=%0d q=%b qn=%b expected q=0 qn=1", cyc, b_q, b_qn);
      end
    end
  end

  task automatic chk(logic ok, string tag, logic q, logic qn);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s q=%b qn=%b expected q=0 qn=1", tag, q, qn);
    end
  endtask

  task automatic wait_until(int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic rise_at(int t);
    wait_until(t);
    a_rise = 1'b1;
    @(negedge clk);
    a_rise = 1'b0;
  endtask

  task automatic fall_at(int t);
    wait_until(t);
    a_fall = 1'b0;
    @(negedge clk);
    a_fall = 1'b1;
  endtask

  task automatic drain();
    while (sbq.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic report();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired at cyc=%0d", cyc);
    report();
  end

  initial begin
    a_rise = 1'b0; a_fall = 1'b1; a_clr = 1'b0; a_ret = 1'b1; a_per = 16'd10;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(a_q === 1'b0 && a_qn === 1'b1, "R8 in reset", a_q, a_qn);
    rst_n = 1'b1;
    @(negedge clk);
    chk(a_q === 1'b0 && a_qn === 1'b1, "R8 after reset", a_q, a_qn);
    chk(b_q === 1'b0 && b_qn === 1'b1, "R10 after reset", b_q, b_qn);
    a_clr = 1'b1;
    repeat (4) @(negedge clk);

    // R1: rising-edge trigger, period 10
    c = cyc;
    expect_win(c+1, c+2, 1'b0, "R1");
    expect_win(c+3, c+12, 1'b1, "R1");
    expect_win(c+13, c+16, 1'b0, "R1");
    rise_at(c);
    drain();

    // R2: falling-edge trigger
    c = cyc;
    expect_win(c+1, c+2, 1'b0, "R2");
    expect_win(c+3, c+12, 1'b1, "R2");
    expect_win(c+13, c+16, 1'b0, "R2");
    fall_at(c);
    drain();

    // R3: rising edge while the other input is low, then opposite-direction edges
    c = cyc;
    expect_win(c+3, c+12, 1'b1, "R3 setup");
    expect_win(c+13, c+32, 1'b0, "R3 rise gated");
    a_fall = 1'b0;
    rise_at(c+16);
    wait_until(c+25);
    a_fall = 1'b1;
    drain();

    // R3: falling edge while the other input is high
    c = cyc;
    expect_win(c+3, c+12, 1'b1, "R3 setup");
    expect_win(c+13, c+32, 1'b0, "R3 fall gated");
    a_rise = 1'b1;
    fall_at(c+16);
    wait_until(c+25);
    a_rise = 1'b0;
    drain();

    // R4: retrigger spaced 5 cycles apart extends the pulse
    c = cyc;
    expect_win(c+3, c+17, 1'b1, "R4");
    expect_win(c+18, c+20, 1'b0, "R4");
    rise_at(c);
    rise_at(c+5);
    drain();

    // R5: spacing 3 is below floor(2*10/5)=4, ignored
    c = cyc;
    expect_win(c+3, c+12, 1'b1, "R5 short");
    expect_win(c+13, c+15, 1'b0, "R5 short");
    rise_at(c);
    rise_at(c+3);
    drain();

    // R5: spacing exactly 4 is accepted
    c = cyc;
    expect_win(c+3, c+16, 1'b1, "R5 boundary");
    expect_win(c+17, c+19, 1'b0, "R5 boundary");
    rise_at(c);
    rise_at(c+4);
    drain();

    // R4: retrigger in the last cycle keeps the output high without a gap
    c = cyc;
    expect_win(c+3, c+22, 1'b1, "R4 last cycle");
    expect_win(c+23, c+25, 1'b0, "R4 last cycle");
    rise_at(c);
    rise_at(c+10);
    drain();

    // R6: non-retriggerable mode
    a_ret = 1'b0;
    @(negedge clk);
    c = cyc;
    expect_win(c+3, c+12, 1'b1, "R6");
    expect_win(c+13, c+15, 1'b0, "R6");
    rise_at(c);
    rise_at(c+5);
    drain();

    c = cyc;
    expect_win(c+3, c+12, 1'b1, "R6 last cycle");
    expect_win(c+13, c+25, 1'b0, "R6 last cycle");
    rise_at(c);
    rise_at(c+10);
    drain();
    a_ret = 1'b1;

    // R9: period 0 and period 1 both give one cycle
    a_per = 16'd0;
    @(negedge clk);
    c = cyc;
    expect_win(c+3, c+3, 1'b1, "R9 zero");
    expect_win(c+4, c+7, 1'b0, "R9 zero");
    rise_at(c);
    drain();
    a_per = 16'd1;
    @(negedge clk);
    c = cyc;
    expect_win(c+3, c+3, 1'b1, "R9 one");
    expect_win(c+4, c+7, 1'b0, "R9 one");
    rise_at(c);
    drain();

    // R9: a period change during the pulse is ignored
    a_per = 16'd10;
    @(negedge clk);
    c = cyc;
    expect_win(c+3, c+12, 1'b1, "R9 change");
    expect_win(c+13, c+15, 1'b0, "R9 change");
    rise_at(c);
    wait_until(c+5);
    a_per = 16'd3;
    drain();
    a_per = 16'd10;
    @(negedge clk);

    // R7: clear during a pulse, a trigger while cleared, then release
    c = cyc;
    expect_win(c+3, c+6, 1'b1, "R7 cut");
    expect_win(c+7, c+26, 1'b0, "R7 cut");
    rise_at(c);
    wait_until(c+5);
    a_clr = 1'b0;
    rise_at(c+10);
    wait_until(c+18);
    a_clr = 1'b1;
    drain();

    // R7: clear and trigger qualified in the same cycle
    c = cyc;
    expect_win(c+1, c+18, 1'b0, "R7 collision");
    a_clr = 1'b0;
    a_rise = 1'b1;
    @(negedge clk);
    a_rise = 1'b0;
    wait_until(c+12);
    a_clr = 1'b1;
    drain();

    // R1: normal operation after the clear is released
    c = cyc;
    expect_win(c+3, c+12, 1'b1, "R1 recovered");
    expect_win(c+13, c+14, 1'b0, "R1 recovered");
    rise_at(c);
    drain();

    report();
  end

endmodule